// File: doc/BRIEF.md
# Quad-Line Instruction Fetch Buffer

This block lets a processor core run code directly out of a shared, wide memory. One memory access returns a 128-bit line that carries four 32-bit instructions. The block stores that line locally, together with the line address it came from. It then serves instructions from the line one per cycle, for as long as the program counter stays inside it. When the program counter leaves the line, or the core signals a branch, the block asks the memory for the line that holds the new program counter and stalls the instruction stream until that line arrives.

The core presents a long-word program counter each cycle and pulses a redirect strobe when a branch, call or return is taken. The instruction for a given program counter comes out one cycle later with a valid flag. The memory side is a request/grant handshake: the block holds a request and a line address until the memory pulses a grant, and the read data bus carries the line in that same cycle. Sharing the memory between several cores happens outside this block.

Top module: `quad_fetch_buffer`

## Requirements
- R1: While reset is high, and in the cycle after it, `instr_valid` and `mem_req` are low.
- R2: The served word is lane `pc[1:0]` of the held line, where lane k occupies bits [32k+31:32k] of `mem_rdata`.
- R3: When `pc[ADDR_W-1:2]` equals the tag of a valid held line and no redirect is given, `instr_valid` is high one cycle later with the matching word, and no memory request is raised.
- R4: On a miss (no valid line, or a tag that differs), `mem_req` rises in the next cycle with `mem_addr` equal to `pc[ADDR_W-1:2]`, and `instr_valid` stays low for as long as the request is pending.
- R5: The line is captured in a cycle where `mem_req` and `mem_gnt` are both high and no redirect is given. The request drops in the next cycle, and the first instruction is valid two cycles after the grant.
- R6: Stepping the program counter from lane 3 into the next line starts a refill. With a grant L cycles after the request first appears, the next instruction is valid 3+L cycles after that program counter is applied.
- R7: A redirect discards the held line, even when the target lies in the same line. `instr_valid` is low in the next cycle, a request follows, and the target is served 3+L cycles after the strobe.
- R8: A redirect to an address that is not line-aligned fetches the enclosing line and serves the addressed lane first. The lanes after it follow, one per cycle, without further requests.
- R9: A redirect that arrives in the same cycle as a grant drops the granted data. The request stays high and moves to the new line address, and no word from the dropped line is ever marked valid.
- R10: A pending request stays high, with a stable address, until it is granted. Only a redirect changes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | ADDR_W | Long-word program counter |
| redirect | input | 1 | Taken branch/call/return strobe; discards the held line |
| mem_req | output | 1 | Line read request to the shared memory |
| mem_addr | output | ADDR_W-2 | Line address (upper program-counter bits) |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 32*SLOTS | Full line read data |
| instr | output | 32 | Instruction for the program counter of the previous cycle |
| instr_valid | output | 1 | `instr` is valid |

## Verification
The hardest case to reach is a redirect that lands in exactly the cycle the memory grants the old line. A stale line written at that moment would be served silently. The bench memory model grants after a programmable number of cycles, so the stimulus counts that delay from the moment it applies a missing address and then fires the redirect on the grant cycle. It does this for several latencies, then checks that the first valid word belongs to the new target and that it arrives at the full refill latency. Unaligned entry is swept over every lane at each latency.

// File: rtl/qfb_pkg.sv
package qfb_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fill_state_e;
endpackage

// File: rtl/qfb_tag_cmp.sv
module qfb_tag_cmp #(
  parameter int TAG_W = 14
) (
  input  logic [TAG_W-1:0] held_tag,
  input  logic             held_ok,
  input  logic [TAG_W-1:0] want_tag,
  output logic             match
);
  always_comb match = held_ok && (held_tag == want_tag);
endmodule

// File: rtl/qfb_fill_ctrl.sv
module qfb_fill_ctrl
  import qfb_pkg::*;
#(
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect,
  input  logic             match,
  input  logic [TAG_W-1:0] want_tag,
  input  logic             mem_gnt,
  output logic             mem_req,
  output logic [TAG_W-1:0] mem_addr,
  output logic             fill_en,
  output logic             serve
);
  fill_state_e      state;
  logic             req_q;
  logic [TAG_W-1:0] addr_q;

  // serve only when idle: no word is offered while a line is outstanding
  always_comb begin
    serve   = (state == FS_IDLE) && match && !redirect;
    fill_en = (state == FS_WAIT) && mem_gnt && !redirect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (redirect || !match) begin
            state  <= FS_WAIT;
            req_q  <= 1'b1;
            addr_q <= want_tag;
          end
        end
        FS_WAIT: begin
          if (redirect) begin
            // retarget; any grant in this cycle is thrown away
            addr_q <= want_tag;
          end else if (mem_gnt) begin
            state <= FS_IDLE;
            req_q <= 1'b0;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/qfb_line_store.sv
module qfb_line_store #(
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 4,
  parameter int TAG_W   = 14,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = INSTR_W * SLOTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [LINE_W-1:0]  fill_line,
  input  logic               drop,
  input  logic [SLOT_W-1:0]  rd_slot,
  input  logic               serve,
  output logic [TAG_W-1:0]   held_tag,
  output logic               held_ok,
  output logic [INSTR_W-1:0] instr,
  output logic               instr_valid
);
  logic [INSTR_W-1:0] fill_lane [SLOTS];
  logic [INSTR_W-1:0] lane_mem  [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_unpack
      assign fill_lane[g] = fill_line[g*INSTR_W +: INSTR_W];
    end
  endgenerate

  // one-cycle write of all lanes, registered read
  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int k = 0; k < SLOTS; k++) lane_mem[k] <= fill_lane[k];
    end
    instr <= lane_mem[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_ok     <= 1'b0;
      held_tag    <= '0;
      instr_valid <= 1'b0;
    end else begin
      instr_valid <= serve;
      if (drop) begin
        held_ok <= 1'b0;
      end else if (fill_en) begin
        held_ok  <= 1'b1;
        held_tag <= fill_tag;
      end
    end
  end
endmodule

// File: rtl/quad_fetch_buffer.sv
module quad_fetch_buffer #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TAG_W  = ADDR_W - SLOT_W,
  localparam int LINE_W = INSTR_W * SLOTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  pc,
  input  logic               redirect,
  output logic               mem_req,
  output logic [TAG_W-1:0]   mem_addr,
  input  logic               mem_gnt,
  input  logic [LINE_W-1:0]  mem_rdata,
  output logic [INSTR_W-1:0] instr,
  output logic               instr_valid
);
  logic [TAG_W-1:0]  pc_tag;
  logic [SLOT_W-1:0] pc_slot;
  logic [TAG_W-1:0]  held_tag;
  logic              held_ok;
  logic              match;
  logic              fill_en;
  logic              serve;

  assign pc_tag  = pc[ADDR_W-1:SLOT_W];
  assign pc_slot = pc[SLOT_W-1:0];

  qfb_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .held_tag (held_tag),
    .held_ok  (held_ok),
    .want_tag (pc_tag),
    .match    (match)
  );

  qfb_fill_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .redirect (redirect),
    .match    (match),
    .want_tag (pc_tag),
    .mem_gnt  (mem_gnt),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .fill_en  (fill_en),
    .serve    (serve)
  );

  qfb_line_store #(
    .INSTR_W (INSTR_W),
    .SLOTS   (SLOTS),
    .TAG_W   (TAG_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .fill_en     (fill_en),
    .fill_tag    (mem_addr),
    .fill_line   (mem_rdata),
    .drop        (redirect),
    .rd_slot     (pc_slot),
    .serve       (serve),
    .held_tag    (held_tag),
    .held_ok     (held_ok),
    .instr       (instr),
    .instr_valid (instr_valid)
  );
endmodule

// File: rtl/qfb_checker.sv
module qfb_checker #(
  parameter int TAG_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             redirect,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic [TAG_W-1:0] mem_addr,
  input logic             instr_valid
);
  // R4: no word is offered while a line is outstanding
  assert_req_valid_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && instr_valid));

  // R10: a request is held until granted
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> mem_req);

  // R10: the address only moves on a redirect
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !redirect) |=> $stable(mem_addr));

  // R5: an accepted grant ends the request
  assert_grant_done_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && !redirect) |=> !mem_req);

  // R7: a redirect drops output and forces a fetch
  assert_redirect_drop_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!instr_valid && mem_req));
endmodule

bind quad_fetch_buffer qfb_checker #(.TAG_W(TAG_W)) u_qfb_chk (
  .clk         (clk),
  .rst         (rst),
  .redirect    (redirect),
  .mem_req     (mem_req),
  .mem_gnt     (mem_gnt),
  .mem_addr    (mem_addr),
  .instr_valid (instr_valid)
);

// File: tb/tb_quad_fetch_buffer.sv
module tb_quad_fetch_buffer;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] pc;
  logic              redirect;
  logic              mem_req;
  logic [TAG_W-1:0]  mem_addr;
  logic              mem_gnt;
  logic [127:0]      mem_rdata;
  logic [31:0]       instr;
  logic              instr_valid;

  int tests = 0;
  int fails = 0;
  int lat   = 0;

  always #4 clk = ~clk;

  quad_fetch_buffer dut (
    .clk(clk), .rst(rst), .pc(pc), .redirect(redirect),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .instr(instr), .instr_valid(instr_valid)
  );

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {a ^ 16'h3C96, a + 16'h1111};
  endfunction

  function automatic logic [127:0] line_of(input logic [TAG_W-1:0] t);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = word_of({t, k[1:0]});
    return r;
  endfunction

  // memory model: grant lat cycles after the request is first seen
  initial begin
    int cnt;
    cnt = 0;
    mem_gnt = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        if (cnt >= lat) begin
          mem_gnt = 1'b1;
          mem_rdata = line_of(mem_addr);
          cnt = 0;
        end else begin
          mem_gnt = 1'b0;
          cnt++;
        end
      end else begin
        mem_gnt = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string msg,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  // apply pc (optionally with redirect) right after a negedge; wait for a valid word
  task automatic go(input logic [15:0] a, input bit br, input int exp_cyc, input string req);
    int n;
    pc = a;
    redirect = br;
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      redirect = 1'b0;
      n++;
      if (n == 1 && exp_cyc > 1) begin
        check(mem_req === 1'b1 && mem_addr === a[15:2], "R4", "request/address after miss",
              {mem_req, mem_addr}, {1'b1, a[15:2]});
      end
      if (!instr_valid && n > 1 && n < exp_cyc - 1) begin
        check(mem_req === 1'b1, "R10", "request held while waiting", mem_req, 1);
      end
    end while (!instr_valid && n < 64);
    check(instr_valid === 1'b1 && instr === word_of(a), req, "served word", instr, word_of(a));
    check(n == exp_cyc, req, "cycles to valid", n, exp_cyc);
  endtask

  initial begin
    rst = 1'b1;
    pc = '0;
    redirect = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(instr_valid === 1'b0 && mem_req === 1'b0, "R1", "reset outputs",
          {instr_valid, mem_req}, 0);
    rst = 1'b0;

    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int s = 0; s < 4; s++) begin
        logic [15:0] a, base;
        a = 16'h0100 * (l + 1) + 16'h0010 * s + s;
        base = a & 16'hFFFC;
        // R8 / R2 / R5: unaligned entry fetches the enclosing line
        go(a, 1'b1, 3 + l, "R8");
        // R3 / R2: remaining lanes are hits
        for (int k = s + 1; k < 4; k++) go(base + k[15:0], 1'b0, 1, "R3");
        // R6: stepping past lane 3 refills
        go(base + 16'd4, 1'b0, 3 + l, "R6");
        // R7: redirect into the line already held still refetches
        go(base + 16'd6, 1'b1, 3 + l, "R7");
        // R3: redirect is not needed for a same-line hit afterwards
        go(base + 16'd5, 1'b0, 1, "R3");
      end
    end

    // R9: redirect lands on the grant cycle
    for (int l = 0; l < 4; l++) begin
      logic [15:0] a, b;
      lat = l;
      a = 16'h0800 + 16'h0040 * l;
      b = 16'h0900 + 16'h0040 * l + 16'd2;
      pc = a;
      redirect = 1'b0;
      for (int c = 0; c < 1 + l; c++) begin
        @(posedge clk);
        @(negedge clk);
        check(instr_valid === 1'b0, "R4", "valid low while line pending", instr_valid, 0);
      end
      check(mem_req === 1'b1 && mem_gnt === 1'b1, "R9", "grant cycle reached",
            {mem_req, mem_gnt}, 2'b11);
      go(b, 1'b1, 3 + l, "R9");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule